// File: doc/BRIEF.md
# Simulation Test Control Peripheral

This block is a bus slave register file that a processor under simulation uses to control its own test run. Behind one base address (default 0x8000_0000) it holds a free-running 64-bit machine timer with a compare value and a level timer interrupt. It also holds two interrupt vectors that software raises and lowers through separate set and clear addresses, a monitor-enable bit, a print stream, and an exit register that records the first completion code written.

The bus side is a pipelined single-master slave. An address phase is accepted on each clock edge where the slave reports ready. Its write data arrives in the cycle that follows, which is the data phase, and the response and read data are given in that same data phase. Addresses outside the register set receive a two-cycle error response. Printing to a console and ending the host process are left to the environment, which watches the print and exit ports.

Top module: `tctl_periph`

## Requirements
- R1: After reset, all of the following are zero: mtime, the compare value, both interrupt vectors, monitor enable, exit valid and print valid. Ready is 1 and error is 0. Because mtime equals the compare value, the timer interrupt is 1.
- R2: An address phase (address, write, transfer type) is captured on every rising edge where ready is 1, and transfer-type bit 1 marks it valid. Write data is sampled on the edge that ends the following data phase. Read data and response are driven during that data phase.
- R3: mtime grows by one on every clock edge that is not a write to mtime. Reads of offset 0x100 return bits 31:0 of its current value and reads of 0x104 return bits 63:32.
- R4: A write to offset 0x100 or 0x104 (mtime) or to 0x108 or 0x10C (compare) replaces only the low or high 32 bits, respectively. The other half keeps its current value, and mtime does not increment on that edge. Compare halves read back at the same offsets.
- R5: The timer interrupt is 1 exactly when mtime is greater than or equal to the compare value, taken as unsigned 64-bit numbers.
- R6: For the 8-bit soft interrupt vector, a write to 0x010 ORs in write-data bits 7:0 and a write to 0x014 clears the bits set in write-data bits 7:0. Reading either offset returns the vector zero-extended.
- R7: For the 32-bit external interrupt vector, a write to 0x020 ORs in the write data and a write to 0x030 clears the bits set in it. Reading either offset returns the vector.
- R8: A write to 0x000 (character) or 0x004 (word) drives print valid high for exactly the cycle after the write's data phase. In that cycle print data carries the full write data, and print word is 0 for 0x000 and 1 for 0x004.
- R9: The first write to 0x008 sets exit valid and stores the write data as the exit code. Until reset, both then hold, and later writes change nothing.
- R10: A write to 0x018 sets monitor enable to 1 if any write-data bit is set and to 0 otherwise.
- R11: Reads of 0x000, 0x004, 0x008 and 0x018 return zero with an OKAY response.
- R12: Any valid access whose full address is not one of the twelve register addresses gets a two-cycle error response. In the first cycle ready is 0 and error is 1; in the second, both are 1. Such an access changes no register.
- R13: An address phase with transfer-type bit 1 clear causes no register change, and its data phase returns ready 1, error 0 and read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 32 | Address-phase byte address |
| bus_write_i | input | 1 | Address-phase write flag |
| bus_size_i | input | 3 | Address-phase transfer size (registers are word-wide; not decoded) |
| bus_trans_i | input | 2 | Transfer type; bit 1 marks a valid transfer |
| bus_wdata_i | input | 32 | Data-phase write data |
| bus_ready_o | output | 1 | Data phase completes this cycle |
| bus_err_o | output | 1 | Error response |
| bus_rdata_o | output | 32 | Data-phase read data |
| soft_irq_o | output | 8 | Soft interrupt vector |
| ext_irq_o | output | 32 | External interrupt vector |
| timer_irq_o | output | 1 | Timer interrupt, mtime >= compare |
| mon_en_o | output | 1 | Monitor enable |
| print_valid_o | output | 1 | Print stream element valid (one cycle) |
| print_word_o | output | 1 | 1: word print, 0: character print |
| print_data_o | output | 32 | Print stream data |
| exit_valid_o | output | 1 | Exit requested (sticky) |
| exit_code_o | output | 32 | Exit code from the first exit write |

## Verification
The assertions check the following on every cycle: the per-edge mtime increment, the half-only replacement on timer writes, the set/clear/hold rules of both interrupt vectors, the ordering of the two error cycles, that an idle address phase never becomes an access, the sticky exit, and that print strobes follow a write. The bench's scenarios must show the rest. That includes the 32-bit carry of mtime into its high half crossing a compare value set in two halves, the exact read-back of each aliased set/clear pair, and zero data from write-only offsets. It also covers unmapped accesses issued back to back with legal ones, which must leave every vector untouched, and a second exit write that must be ignored.

// File: rtl/tctl_pkg.sv
package tctl_pkg;

  localparam int OFS_W = 12;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PCHAR, SEL_PWORD, SEL_EXIT, SEL_SSET, SEL_SCLR, SEL_MON,
    SEL_ISET, SEL_ICLR, SEL_MT_LO, SEL_MT_HI, SEL_CMP_LO, SEL_CMP_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      12'h000: decode_ofs = SEL_PCHAR;
      12'h004: decode_ofs = SEL_PWORD;
      12'h008: decode_ofs = SEL_EXIT;
      12'h010: decode_ofs = SEL_SSET;
      12'h014: decode_ofs = SEL_SCLR;
      12'h018: decode_ofs = SEL_MON;
      12'h020: decode_ofs = SEL_ISET;
      12'h030: decode_ofs = SEL_ICLR;
      12'h100: decode_ofs = SEL_MT_LO;
      12'h104: decode_ofs = SEL_MT_HI;
      12'h108: decode_ofs = SEL_CMP_LO;
      12'h10C: decode_ofs = SEL_CMP_HI;
      default: decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tctl_bus_fe.sv
module tctl_bus_fe
  import tctl_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h8000_0000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        trans_i,
  output logic              ready_o,
  output logic              err_o,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o
);

  logic              dp_vld_q, dp_wr_q, err2_q;
  logic [ADDR_W-1:0] dp_addr_q;
  reg_sel_e          dp_sel;
  logic              bad;

  logic unused_fe;
  assign unused_fe = ^{trans_i[0], size_i};

  always_comb begin
    dp_sel = SEL_NONE;
    if (dp_addr_q[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W])
      dp_sel = decode_ofs(dp_addr_q[OFS_W-1:0]);
  end

  assign bad     = dp_vld_q && (dp_sel == SEL_NONE);
  assign ready_o = !(bad && !err2_q);
  assign err_o   = bad;
  assign sel_o   = dp_sel;
  assign wr_o    = dp_vld_q && dp_wr_q && !bad;
  assign rd_o    = dp_vld_q && !dp_wr_q && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_vld_q  <= 1'b0;
      dp_wr_q   <= 1'b0;
      dp_addr_q <= '0;
      err2_q    <= 1'b0;
    end else begin
      if (ready_o) begin
        dp_vld_q  <= trans_i[1];
        dp_wr_q   <= write_i;
        dp_addr_q <= addr_i;
      end
      err2_q <= bad && !err2_q;
    end
  end

  // R12: stall cycle is always followed by the completing error cycle
  assert_err_two_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !ready_o) |=> (err_o && ready_o));
  assert_stall_only_on_err_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> err_o);
  // R13: idle address phase never turns into an access
  assert_idle_no_access_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !trans_i[1]) |=> !(wr_o || rd_o || err_o));
  // R2: accepted valid phase yields exactly one kind of data phase
  assert_phase_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && trans_i[1]) |=> $onehot({wr_o, rd_o, err_o}));

endmodule

// File: rtl/tctl_timer.sv
module tctl_timer #(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mt_lo_we_i,
  input  logic              mt_hi_we_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [TIME_W-1:0] mtime_o,
  output logic [TIME_W-1:0] cmp_o,
  output logic              irq_o
);

  logic [TIME_W-1:0] mtime_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mtime_q <= '0;
      cmp_q   <= '0;
    end else begin
      if (mt_lo_we_i)      mtime_q <= {mtime_q[TIME_W-1:DATA_W], data_i};
      else if (mt_hi_we_i) mtime_q <= {data_i, mtime_q[DATA_W-1:0]};
      else                 mtime_q <= mtime_q + TIME_W'(1);
      if (cmp_lo_we_i)      cmp_q <= {cmp_q[TIME_W-1:DATA_W], data_i};
      else if (cmp_hi_we_i) cmp_q <= {data_i, cmp_q[DATA_W-1:0]};
    end
  end

  assign mtime_o = mtime_q;
  assign cmp_o   = cmp_q;
  assign irq_o   = (mtime_q >= cmp_q);

  assert_mtime_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mt_lo_we_i || mt_hi_we_i) |=> (mtime_o == $past(mtime_o) + TIME_W'(1)));
  assert_mtime_lo_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mt_lo_we_i |=> (mtime_o[TIME_W-1:DATA_W] == $past(mtime_o[TIME_W-1:DATA_W]))
                && (mtime_o[DATA_W-1:0] == $past(data_i)));
  assert_cmp_hi_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_hi_we_i |=> (cmp_o[DATA_W-1:0] == $past(cmp_o[DATA_W-1:0]))
                 && (cmp_o[TIME_W-1:DATA_W] == $past(data_i)));
  assert_cmp_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_lo_we_i || cmp_hi_we_i) |=> $stable(cmp_o));

endmodule

// File: rtl/tctl_irq_bank.sv
module tctl_irq_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] vec_o
);

  logic [W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_q <= '0;
    else if (set_i) vec_q <= vec_q | data_i;
    else if (clr_i) vec_q <= vec_q & ~data_i;
  end

  assign vec_o = vec_q;

  // R6/R7 shared rules for both vectors
  assert_set_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((vec_o & $past(data_i)) == $past(data_i)) && ((vec_o & ~$past(data_i)) == ($past(vec_o) & ~$past(data_i))));
  assert_clr_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vec_o == ($past(vec_o) & ~$past(data_i))));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i || clr_i) |=> $stable(vec_o));

endmodule

// File: rtl/tctl_periph.sv
module tctl_periph
  import tctl_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                SOFT_W    = 8,
  parameter int                EXT_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h8000_0000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_write_i,
  input  logic [2:0]        bus_size_i,
  input  logic [1:0]        bus_trans_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ready_o,
  output logic              bus_err_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [SOFT_W-1:0] soft_irq_o,
  output logic [EXT_W-1:0]  ext_irq_o,
  output logic              timer_irq_o,
  output logic              mon_en_o,
  output logic              print_valid_o,
  output logic              print_word_o,
  output logic [DATA_W-1:0] print_data_o,
  output logic              exit_valid_o,
  output logic [DATA_W-1:0] exit_code_o
);

  localparam int TIME_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic              wr_en, rd_en;
  logic [TIME_W-1:0] mtime, cmp;
  logic              pv_q, pw_q, mon_q, exit_q;
  logic [DATA_W-1:0] pd_q, code_q;

  tctl_bus_fe #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_fe (
    .clk_i, .rst_ni,
    .addr_i (bus_addr_i),
    .write_i(bus_write_i),
    .size_i (bus_size_i),
    .trans_i(bus_trans_i),
    .ready_o(bus_ready_o),
    .err_o  (bus_err_o),
    .sel_o  (sel),
    .wr_o   (wr_en),
    .rd_o   (rd_en)
  );

  tctl_timer #(.DATA_W(DATA_W)) u_timer (
    .clk_i, .rst_ni,
    .mt_lo_we_i (wr_en && sel == SEL_MT_LO),
    .mt_hi_we_i (wr_en && sel == SEL_MT_HI),
    .cmp_lo_we_i(wr_en && sel == SEL_CMP_LO),
    .cmp_hi_we_i(wr_en && sel == SEL_CMP_HI),
    .data_i     (bus_wdata_i),
    .mtime_o    (mtime),
    .cmp_o      (cmp),
    .irq_o      (timer_irq_o)
  );

  tctl_irq_bank #(.W(SOFT_W)) u_soft (
    .clk_i, .rst_ni,
    .set_i (wr_en && sel == SEL_SSET),
    .clr_i (wr_en && sel == SEL_SCLR),
    .data_i(bus_wdata_i[SOFT_W-1:0]),
    .vec_o (soft_irq_o)
  );

  tctl_irq_bank #(.W(EXT_W)) u_ext (
    .clk_i, .rst_ni,
    .set_i (wr_en && sel == SEL_ISET),
    .clr_i (wr_en && sel == SEL_ICLR),
    .data_i(bus_wdata_i[EXT_W-1:0]),
    .vec_o (ext_irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (sel)
        SEL_SSET, SEL_SCLR: bus_rdata_o = DATA_W'(soft_irq_o);
        SEL_ISET, SEL_ICLR: bus_rdata_o = DATA_W'(ext_irq_o);
        SEL_MT_LO:          bus_rdata_o = mtime[DATA_W-1:0];
        SEL_MT_HI:          bus_rdata_o = mtime[TIME_W-1:DATA_W];
        SEL_CMP_LO:         bus_rdata_o = cmp[DATA_W-1:0];
        SEL_CMP_HI:         bus_rdata_o = cmp[TIME_W-1:DATA_W];
        default:            bus_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q   <= 1'b0;
      pw_q   <= 1'b0;
      pd_q   <= '0;
      mon_q  <= 1'b0;
      exit_q <= 1'b0;
      code_q <= '0;
    end else begin
      pv_q <= wr_en && (sel == SEL_PCHAR || sel == SEL_PWORD);
      if (wr_en && (sel == SEL_PCHAR || sel == SEL_PWORD)) begin
        pw_q <= (sel == SEL_PWORD);
        pd_q <= bus_wdata_i;
      end
      if (wr_en && sel == SEL_MON) mon_q <= |bus_wdata_i;
      if (wr_en && sel == SEL_EXIT && !exit_q) begin
        exit_q <= 1'b1;
        code_q <= bus_wdata_i;
      end
    end
  end

  assign print_valid_o = pv_q;
  assign print_word_o  = pw_q;
  assign print_data_o  = pd_q;
  assign mon_en_o      = mon_q;
  assign exit_valid_o  = exit_q;
  assign exit_code_o   = code_q;

  assert_exit_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |=> (exit_valid_o && $stable(exit_code_o)));
  assert_print_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    print_valid_o |-> ($past(wr_en) && (print_data_o == $past(bus_wdata_i))));
  assert_mon_follows_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && sel == SEL_MON) |=> $stable(mon_en_o));
  assert_err_reads_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (bus_rdata_o == '0));

endmodule

// File: tb/tctl_periph_bench.sv
module tctl_periph_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_size = 3'd2;
  logic [1:0]  bus_trans = 2'b00;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready_o, bus_err_o, timer_irq_o, mon_en_o;
  logic        print_valid_o, print_word_o, exit_valid_o;
  logic [31:0] bus_rdata_o, ext_irq_o, print_data_o, exit_code_o;
  logic [7:0]  soft_irq_o;

  always #2.5 clk = ~clk;

  tctl_periph u_tctl_periph (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_write_i(bus_write), .bus_size_i(bus_size),
    .bus_trans_i(bus_trans), .bus_wdata_i(bus_wdata),
    .bus_ready_o, .bus_err_o, .bus_rdata_o,
    .soft_irq_o, .ext_irq_o, .timer_irq_o, .mon_en_o,
    .print_valid_o, .print_word_o, .print_data_o,
    .exit_valid_o, .exit_code_o
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] pend = '0;

  // reference model state
  bit          m_vld, m_wr, m_err2, m_mon, m_exv, m_pv, m_pw;
  logic [31:0] m_addr, m_code, m_pd, m_ext;
  logic [7:0]  m_soft;
  logic [63:0] m_mt, m_cmp, nt;
  int          k;
  bit          bad, rdy, commit;

  function automatic int kind(logic [31:0] a);
    case (a)
      32'h8000_0000: return 1;  32'h8000_0004: return 2;
      32'h8000_0008: return 3;  32'h8000_0010: return 4;
      32'h8000_0014: return 5;  32'h8000_0018: return 6;
      32'h8000_0020: return 7;  32'h8000_0030: return 8;
      32'h8000_0100: return 9;  32'h8000_0104: return 10;
      32'h8000_0108: return 11; 32'h8000_010C: return 12;
      default:       return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!m_vld || m_wr) return '0;
    case (kind(m_addr))
      4, 5:    return {24'h0, m_soft};
      7, 8:    return m_ext;
      9:       return m_mt[31:0];
      10:      return m_mt[63:32];
      11:      return m_cmp[31:0];
      12:      return m_cmp[63:32];
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag();
    if (!m_vld) return "R13";
    case (kind(m_addr))
      0:       return "R12";
      1, 2, 3, 6: return "R11";
      4, 5:    return "R6";
      7, 8:    return "R7";
      9, 10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_wr = 0; m_err2 = 0; m_mon = 0; m_exv = 0; m_pv = 0; m_pw = 0;
      m_addr = '0; m_code = '0; m_pd = '0; m_ext = '0; m_soft = '0;
      m_mt = '0; m_cmp = '0;
    end else begin
      k      = kind(m_addr);
      bad    = m_vld && k == 0;
      rdy    = !(bad && !m_err2);
      commit = m_vld && m_wr && !bad;
      nt     = m_mt + 64'd1;
      m_pv   = 0;
      if (commit) begin
        case (k)
          1, 2: begin m_pv = 1; m_pw = (k == 2); m_pd = bus_wdata; end
          3:  if (!m_exv) begin m_exv = 1; m_code = bus_wdata; end
          4:  m_soft = m_soft | bus_wdata[7:0];
          5:  m_soft = m_soft & ~bus_wdata[7:0];
          6:  m_mon = |bus_wdata;
          7:  m_ext = m_ext | bus_wdata;
          8:  m_ext = m_ext & ~bus_wdata;
          9:  nt = {m_mt[63:32], bus_wdata};
          10: nt = {bus_wdata, m_mt[31:0]};
          11: m_cmp = {m_cmp[63:32], bus_wdata};
          12: m_cmp = {bus_wdata, m_cmp[31:0]};
          default: ;
        endcase
      end
      m_mt   = nt;
      m_err2 = bad && !m_err2;
      if (rdy) begin m_vld = bus_trans[1]; m_wr = bus_write; m_addr = bus_addr; end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit eb;
      eb = m_vld && kind(m_addr) == 0;
      chk("R12", "ready", bus_ready_o, !(eb && !m_err2));
      chk("R12", "err", bus_err_o, eb);
      chk(rd_tag(), "rdata", bus_rdata_o, exp_rdata());
      chk("R6", "soft_irq", soft_irq_o, m_soft);
      chk("R7", "ext_irq", ext_irq_o, m_ext);
      chk("R5", "timer_irq", timer_irq_o, m_mt >= m_cmp);
      chk("R10", "mon_en", mon_en_o, m_mon);
      chk("R8", "print_valid", print_valid_o, m_pv);
      if (m_pv) begin
        chk("R8", "print_word", print_word_o, m_pw);
        chk("R8", "print_data", print_data_o, m_pd);
      end
      chk("R9", "exit_valid", exit_valid_o, m_exv);
      if (m_exv) chk("R9", "exit_code", exit_code_o, m_code);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      finish_run();
    end
  end

  // one address phase; data for the previous phase is driven alongside
  task automatic op(logic [1:0] tr, bit wr, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wdata = pend;
    pend      = d;
    bus_trans = tr;
    bus_write = wr;
    bus_addr  = a;
    while (!bus_ready_o) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] ofs, logic [31:0] d);
    op(2'b10, 1, 32'h8000_0000 + ofs, d);
  endtask
  task automatic rd(logic [31:0] ofs);
    op(2'b10, 0, 32'h8000_0000 + ofs, '0);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(2'b00, 0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "timer_irq", timer_irq_o, 1);
    chk("R1", "ready", bus_ready_o, 1);
    chk("R1", "err", bus_err_o, 0);
    chk("R1", "vectors", {soft_irq_o, ext_irq_o}, 0);
    chk("R1", "flags", {mon_en_o, exit_valid_o, print_valid_o}, 0);

    // R3 back-to-back mtime reads
    rd(32'h100); rd(32'h100); rd(32'h104); idle(1);
    // R4/R5 compare in halves, mtime carry across halves
    wr(32'h108, 32'd200); idle(2);
    chk("R5", "irq after cmp=200", timer_irq_o, 0);
    idle(200);
    chk("R5", "irq after mtime passes 200", timer_irq_o, 1);
    wr(32'h10C, 32'd2); wr(32'h108, 32'd5);
    wr(32'h100, 32'hFFFF_FFF0); wr(32'h104, 32'd1);
    rd(32'h108); rd(32'h10C); rd(32'h100); rd(32'h104);
    idle(1);
    chk("R4", "irq below split compare", timer_irq_o, 0);
    idle(30);
    chk("R4", "irq after carry into high half", timer_irq_o, 1);

    // R6 soft vector, upper data bits ignored
    wr(32'h010, 32'h0000_FFA5); wr(32'h014, 32'h05); rd(32'h010); rd(32'h014);
    idle(1);
    chk("R6", "soft vector", soft_irq_o, 8'hA0);
    // R7 external vector
    wr(32'h020, 32'hF0F0_1234); wr(32'h030, 32'h0000_0234); rd(32'h030); rd(32'h020);
    idle(1);
    chk("R7", "ext vector", ext_irq_o, 32'hF0F0_1000);

    // R8 print stream back to back
    wr(32'h000, 32'h41); wr(32'h004, 32'hDEAD_BEEF); idle(3);
    // R10 monitor enable
    wr(32'h018, 32'h100); idle(2);
    chk("R10", "mon set", mon_en_o, 1);
    wr(32'h018, 32'h0); idle(2);
    chk("R10", "mon clear", mon_en_o, 0);
    // R9 exit once
    wr(32'h008, 32'd7); wr(32'h008, 32'd9); idle(3);
    chk("R9", "exit code kept", exit_code_o, 32'd7);
    chk("R9", "exit valid", exit_valid_o, 1);
    // R11 write-only reads
    rd(32'h000); rd(32'h004); rd(32'h008); rd(32'h018); idle(1);

    // R12 unmapped, wrong base, back to back with legal access
    rd(32'h040); wr(32'h200, 32'hFF); op(2'b10, 1, 32'h0000_0010, 32'hFF);
    rd(32'h010); idle(2);
    chk("R12", "soft after unmapped writes", soft_irq_o, 8'hA0);

    // R13 idle and busy phases carrying write addresses
    op(2'b00, 1, 32'h8000_0010, 32'h0F); op(2'b01, 1, 32'h8000_0020, 32'h0F);
    op(2'b01, 1, 32'h8000_0008, 32'h3); idle(2);
    chk("R13", "soft after idle", soft_irq_o, 8'hA0);
    chk("R13", "ext after busy", ext_irq_o, 32'hF0F0_1000);
    chk("R13", "rdata idle", bus_rdata_o, 0);

    idle(2);
    finish_run();
  end

endmodule